// File: doc/BRIEF.md
# Shared Address/Data Bus Transaction Issuer

This block is the master-side issue engine for a 64-bit bus that carries address information and data on the same wires in different cycles. A local client presents one read or write request at a time. The request carries a type code, a 40-bit physical address, a 10-bit cache index, a line size and a transaction tag. The block issues each transaction as one address beat. A write follows its address beat with two, four or eight doubleword data beats, in consecutive cycles.

The bus has no abort and no retry. The block therefore issues only when it holds the bus grant and the receiving side has already signalled that it can take the transaction. While a write burst is in flight, the block holds further requests off. A request that uses the reserved line-size code is consumed without any bus activity, and the block flags it.

Top module: `mbus_issuer`

## Requirements
- R1: After synchronous reset, `bus_valid`, `bus_kind`, `bus_data`, `wdata_take` and `req_reject` are all 0.
- R2: `req_ready` is high exactly when no write burst is in progress and both `grant` and `permit` are high. A request is consumed in a cycle where `req_valid` and `req_ready` are both high.
- R3: For a consumed request with a valid size, the next cycle shows `bus_valid`=1 and `bus_kind`=0 (address beat). `bus_data` holds {size[63:62], tag[61:57], master ID[56:54], type[53:50], index[49:40], address[39:0]}.
- R4: A write of size code 00, 01 or 10 (16, 32 or 64 bytes) is followed directly by 2, 4 or 8 data beats in gapless cycles. Each data beat has `bus_kind`=1. During each data beat's preceding cycle `wdata_take` is 1, and the beat carries the `wdata` value presented in that cycle.
- R5: A read issues only its address beat, with no data beats and no `wdata_take`. Reads consumed in consecutive cycles give consecutive address beats.
- R6: A consumed request with size code 11 produces no bus beat. In the following cycle it raises `req_reject` for exactly one cycle.
- R7: `req_ready` is 0 in every cycle in which `wdata_take` is 1.
- R8: A request presented while the last data beat of a write is on the bus is consumed at once. Its address beat follows that data beat with no idle cycle.
- R9: With `permit` low or `grant` low, no request is consumed and no address beat appears.
- R10: In any cycle with `bus_valid`=0, `bus_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Request can be consumed this cycle |
| req_write | input | 1 | 1 = write (data beats follow), 0 = read |
| req_type | input | 4 | Transaction type code carried in the address beat |
| req_addr | input | 40 | Physical address |
| req_vidx | input | 10 | Cache index |
| req_size | input | 2 | Line size: 00=16B, 01=32B, 10=64B, 11 reserved |
| req_tid | input | 5 | Transaction tag |
| wdata | input | 64 | Write doubleword for the next data beat |
| wdata_take | output | 1 | `wdata` is consumed at this clock edge |
| grant | input | 1 | Bus mastership granted |
| permit | input | 1 | Receiver can accept a transaction |
| bus_valid | output | 1 | A beat is on the bus |
| bus_kind | output | 1 | 0 = address beat, 1 = data beat |
| bus_data | output | 64 | Bus word |
| req_reject | output | 1 | Reserved-size request was dropped |

## Verification
Random request streams mix reads and writes over all four size codes, with random address, index, type and tag fields. The field mixing separates wrong bit positions in the address beat, and the mix of sizes catches beat counts that are off. Directed sequences hold requests back-to-back, including right behind the last data beat of a write, to catch lost or inserted idle cycles. Other directed cases drop `permit` or `grant` on their own to tell the two gates apart. Reserved-size requests check that nothing reaches the bus and that the reject pulse has the right timing.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    localparam int BUS_W  = 64;
    localparam int PA_W   = 40;
    localparam int VIDX_W = 10;
    localparam int TYPE_W = 4;
    localparam int MID_W  = 3;
    localparam int TID_W  = 5;
    localparam int SIZE_W = 2;
    localparam int CNT_W  = 4;

    typedef enum logic [SIZE_W-1:0] {
        LS_16   = 2'b00,
        LS_32   = 2'b01,
        LS_64   = 2'b10,
        LS_RSVD = 2'b11
    } line_size_e;

    typedef enum logic {
        BEAT_ADDR = 1'b0,
        BEAT_DATA = 1'b1
    } beat_kind_e;

    typedef struct packed {
        line_size_e          size;
        logic [TID_W-1:0]    tid;
        logic [MID_W-1:0]    mid;
        logic [TYPE_W-1:0]   ttype;
        logic [VIDX_W-1:0]   vidx;
        logic [PA_W-1:0]     addr;
    } addr_beat_t;

    function automatic logic [CNT_W-1:0] data_beats(line_size_e s);
        case (s)
            LS_16:   return CNT_W'(2);
            LS_32:   return CNT_W'(4);
            LS_64:   return CNT_W'(8);
            default: return '0;
        endcase
    endfunction

    function automatic logic size_ok(line_size_e s);
        return s != LS_RSVD;
    endfunction
endpackage

// File: rtl/mbus_beat_fmt.sv
module mbus_beat_fmt
    import mbus_pkg::*;
#(
    parameter logic [MID_W-1:0] MASTER_ID = '0
) (
    input  line_size_e          size,
    input  logic [TID_W-1:0]    tid,
    input  logic [TYPE_W-1:0]   ttype,
    input  logic [VIDX_W-1:0]   vidx,
    input  logic [PA_W-1:0]     addr,
    output addr_beat_t          beat
);
    always_comb begin
        beat.size  = size;
        beat.tid   = tid;
        beat.mid   = MASTER_ID;
        beat.ttype = ttype;
        beat.vidx  = vidx;
        beat.addr  = addr;
    end
endmodule

// File: rtl/mbus_burst_ctl.sv
module mbus_burst_ctl
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  line_size_e size,
    output logic       busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= data_beats(size);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy = (cnt_q != '0);

    // R7: a new burst never starts over a running one
    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R4: a burst begins with a legal beat count
    a_r4_burst_len: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cnt_q == CNT_W'(2) || cnt_q == CNT_W'(4) || cnt_q == CNT_W'(8)));
endmodule

// File: rtl/mbus_issuer.sv
module mbus_issuer
    import mbus_pkg::*;
#(
    parameter logic [MID_W-1:0] MASTER_ID = 3'd5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [PA_W-1:0]   req_addr,
    input  logic [VIDX_W-1:0] req_vidx,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [BUS_W-1:0]  wdata,
    output logic              wdata_take,
    input  logic              grant,
    input  logic              permit,
    output logic              bus_valid,
    output logic              bus_kind,
    output logic [BUS_W-1:0]  bus_data,
    output logic              req_reject
);
    line_size_e size_in;
    addr_beat_t abeat;
    logic       busy, accept, good, start;
    beat_kind_e kind_q;

    assign size_in = line_size_e'(req_size);

    mbus_beat_fmt #(.MASTER_ID(MASTER_ID)) u_fmt (
        .size  (size_in),
        .tid   (req_tid),
        .ttype (req_type),
        .vidx  (req_vidx),
        .addr  (req_addr),
        .beat  (abeat)
    );

    mbus_burst_ctl u_burst (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .size  (size_in),
        .busy  (busy)
    );

    assign req_ready  = !busy && grant && permit;
    assign accept     = req_valid && req_ready;
    assign good       = accept && size_ok(size_in);
    assign start      = good && req_write;
    assign wdata_take = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_valid  <= 1'b0;
            kind_q     <= BEAT_ADDR;
            bus_data   <= '0;
            req_reject <= 1'b0;
        end else begin
            req_reject <= accept && !size_ok(size_in);
            if (good) begin
                bus_valid <= 1'b1;
                kind_q    <= BEAT_ADDR;
                bus_data  <= abeat;
            end else if (busy) begin
                bus_valid <= 1'b1;
                kind_q    <= BEAT_DATA;
                bus_data  <= wdata;
            end else begin
                bus_valid <= 1'b0;
                kind_q    <= BEAT_ADDR;
                bus_data  <= '0;
            end
        end
    end

    assign bus_kind = kind_q;

    // R2 / R9: an address beat only follows a cycle with grant and permit
    a_r9_gated_issue: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_kind) |-> $past(grant && permit && req_valid));

    // R7: no request accepted while write data is being consumed
    a_r7_hold_off: assert property (@(posedge clk) disable iff (rst)
        wdata_take |-> !req_ready);

    // R4: every consumed doubleword appears as a data beat next cycle
    a_r4_no_gap: assert property (@(posedge clk) disable iff (rst)
        wdata_take |=> (bus_valid && bus_kind));

    // R6: reserved size gives a reject pulse and an idle bus
    a_r6_reject: assert property (@(posedge clk) disable iff (rst)
        (accept && req_size == 2'b11) |=> (req_reject && !bus_valid));

    // R5: a read leaves no data phase behind
    a_r5_read_only: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && req_size != 2'b11) |=> (bus_valid && !bus_kind && !wdata_take));

    // R10: idle bus carries zeros
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (bus_data == '0));
endmodule

// File: tb/mbus_issuer_tb.sv
module mbus_issuer_tb;
    localparam logic [2:0] TB_MID = 3'd6;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [3:0]  req_type;
    logic [39:0] req_addr;
    logic [9:0]  req_vidx;
    logic [1:0]  req_size;
    logic [4:0]  req_tid;
    logic [63:0] wdata;
    logic        wdata_take, grant, permit;
    logic        bus_valid, bus_kind, req_reject;
    logic [63:0] bus_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    mbus_issuer #(.MASTER_ID(TB_MID)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_type(req_type), .req_addr(req_addr), .req_vidx(req_vidx),
        .req_size(req_size), .req_tid(req_tid),
        .wdata(wdata), .wdata_take(wdata_take),
        .grant(grant), .permit(permit),
        .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_data(bus_data),
        .req_reject(req_reject)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_abeat(logic [1:0] s, logic [4:0] t,
                                              logic [3:0] ty, logic [9:0] v, logic [39:0] a);
        return {s, t, TB_MID, ty, v, a};
    endfunction

    function automatic int exp_beats(logic [1:0] s);
        return (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : (s == 2'b10) ? 8 : 0;
    endfunction

    function automatic logic [63:0] dpat(logic [31:0] seed, int i);
        return {seed, seed ^ (32'h9e37_79b9 * (i + 1))};
    endfunction

    // Called at a negedge; returns at a negedge with the last beat on the bus.
    task automatic run_txn(bit wr, logic [3:0] ty, logic [39:0] a, logic [9:0] v,
                           logic [1:0] s, logic [4:0] t, bit after_write);
        logic [31:0] seed = $urandom;
        req_valid = 1; req_write = wr; req_type = ty; req_addr = a;
        req_vidx = v; req_size = s; req_tid = t; grant = 1; permit = 1;
        #1;
        check(after_write ? "R8 ready behind last data" : "R2 ready when idle",
              64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 0;
        if (s == 2'b11) begin
            check("R6 no beat", 64'(bus_valid), 64'd0);
            check("R6 reject pulse", 64'(req_reject), 64'd1);
            check("R10 idle zero", bus_data, 64'd0);
            @(negedge clk);
            check("R6 pulse one cycle", 64'(req_reject), 64'd0);
            return;
        end
        check(after_write ? "R8 addr beat no gap" : "R3 addr valid", 64'(bus_valid), 64'd1);
        check("R3 addr kind", 64'(bus_kind), 64'd0);
        check("R3 addr fields", bus_data, exp_abeat(s, t, ty, v, a));
        if (!wr) begin
            check("R5 no take on read", 64'(wdata_take), 64'd0);
            return;
        end
        for (int i = 0; i < exp_beats(s); i++) begin
            check("R4 take", 64'(wdata_take), 64'd1);
            check("R7 ready low in burst", 64'(req_ready), 64'd0);
            wdata = dpat(seed, i);
            @(negedge clk);
            check("R4 data valid", 64'(bus_valid), 64'd1);
            check("R4 data kind", 64'(bus_kind), 64'd1);
            check("R4 data value", bus_data, dpat(seed, i));
        end
        check("R4 burst length", 64'(wdata_take), 64'd0);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; req_valid = 0; req_write = 0; req_type = 0; req_addr = 0;
        req_vidx = 0; req_size = 0; req_tid = 0; wdata = 0; grant = 0; permit = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 bus_valid", 64'(bus_valid), 64'd0);
        check("R1 bus_kind", 64'(bus_kind), 64'd0);
        check("R1 bus_data", bus_data, 64'd0);
        check("R1 take", 64'(wdata_take), 64'd0);
        check("R1 reject", 64'(req_reject), 64'd0);
        rst = 0;
        @(negedge clk);

        // R9: permit low, then grant low
        req_valid = 1; req_size = 2'b00; req_write = 0; grant = 1; permit = 0;
        #1 check("R9 ready no permit", 64'(req_ready), 64'd0);
        @(negedge clk);
        check("R9 no beat no permit", 64'(bus_valid), 64'd0);
        grant = 0; permit = 1;
        #1 check("R9 ready no grant", 64'(req_ready), 64'd0);
        @(negedge clk);
        check("R9 no beat no grant", 64'(bus_valid), 64'd0);
        check("R10 idle zero", bus_data, 64'd0);
        req_valid = 0;

        // Directed: each size as a write, back-to-back (R8), then reads back-to-back (R5)
        run_txn(1, 4'h3, 40'hff_ffff_ffff, 10'h3ff, 2'b00, 5'h1f, 0);
        run_txn(1, 4'ha, 40'h12_3456_789a, 10'h155, 2'b01, 5'h0a, 1);
        run_txn(1, 4'h5, 40'h00_0000_0001, 10'h2aa, 2'b10, 5'h15, 1);
        run_txn(0, 4'hf, 40'h80_0000_0000, 10'h001, 2'b10, 5'h01, 1);
        run_txn(0, 4'h1, 40'h7f_ffff_fff0, 10'h200, 2'b00, 5'h10, 0);
        run_txn(1, 4'h2, 40'h55_5555_5555, 10'h0f0, 2'b11, 5'h02, 0);
        @(negedge clk);
        check("R10 idle after traffic", bus_data, 64'd0);

        // Random mix
        begin
            bit prev_wr = 0;
            for (int k = 0; k < 60; k++) begin
                bit wr = $urandom_range(0, 1);
                logic [1:0] s = 2'($urandom_range(0, 3));
                run_txn(wr, 4'($urandom), {8'($urandom), 32'($urandom)},
                        10'($urandom), s, 5'($urandom), prev_wr);
                prev_wr = wr && (s != 2'b11);
                if ($urandom_range(0, 3) == 0) begin
                    req_valid = 0;
                    @(negedge clk);
                    prev_wr = 0;
                end
            end
        end
        req_valid = 0;
        @(negedge clk);
        check("R5 bus quiet at end", 64'(bus_valid), 64'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule